// File: doc/BRIEF.md
# MMU System Control Register File

This block is the register file that a processor core's system-control coprocessor uses to configure and observe its memory management unit. Software reaches it through a coprocessor instruction word: a primary register number and a secondary opcode pick the target, a write flag chooses the direction, and a 32-bit data word goes with writes. The block holds these registers:

- the MMU control word
- the translation table base
- the domain access word
- separate data-side and instruction-side fault status and fault address registers
- a process identifier
- a context identifier

It also answers identification reads with fixed values.

Some writes have side effects. In those cases the block emits a single-cycle TLB invalidate pulse that the translation logic acts on. A separate hardware capture port is driven by the table walker when a translation aborts. The block loads the fault status and fault address into the data-side or instruction-side pair, depending on the access type, and pulses the matching abort output. Any encoding that is reserved or not implemented is answered with a single-cycle undefined-access flag and changes no state.

Every response is registered. Read data, the undefined flag, the invalidate pulse and the abort pulses all appear in the cycle after the access or capture that caused them.

Top module: `mmu_ctl_regfile`

## Requirements
- R1: After synchronous active-low reset, every writable register reads as zero and `rd_valid`, `rd_data`, `acc_undef`, `tlb_inval`, `pabt` and `dabt` are all 0.
- R2: The primary register number is taken from `acc_insn[19:16]` and the secondary opcode from `acc_insn[7:5]`. All other instruction bits are ignored. A read (`acc_valid`=1, `acc_write`=0) gives `rd_valid`=1 one cycle later with its data on `rd_data`. `rd_data` is 0 whenever `rd_valid` is 0.
- R3: Some accesses are undefined:
  - any access to primary 4, 7, 9, 11, 12 or 14
  - a write to primary 0
  - any access to primary 1 with an opcode other than 0
  - a read of primary 8
  - a write to primary 8 with an opcode above 1
  - any access to primary 5, 6 or 13 with an opcode above 1

  Each of these raises `acc_undef` for one cycle, one cycle after the access, and changes no register. An undefined read returns data 0.
- R4: A write to primary 1 with opcode 0 loads the control word and raises `tlb_inval` for one cycle, one cycle later. A read of primary 1 with opcode 0 returns the control word.
- R5: Primary 2 (table base) and primary 3 (domain access) are readable and writable with any opcode.
- R6: In primary 5, opcode 0 selects the data fault status and opcode 1 the instruction fault status. Primary 6 uses the same two opcodes for the data and instruction fault addresses.
- R7: A write to primary 8 with opcode 0 or 1 raises `tlb_inval` for one cycle and changes no register.
- R8: A read of primary 0 returns 0x01DD20D2 for opcode 1, zero for opcode 2, and the `CPU_ID` parameter for every other opcode.
- R9: A read of primary 10 or 15 returns zero. A write to either is accepted without `acc_undef` or `tlb_inval` and stores nothing.
- R10: In primary 13, opcode 0 selects the process identifier and opcode 1 the context identifier. Both are readable and writable.
- R11: When `abt_valid` is 1 with `abt_kind`=2 (instruction fetch), `abt_status` and `abt_addr` are loaded into the instruction-side status and address registers, and `pabt` pulses one cycle later. Any other `abt_kind` loads the data-side pair and pulses `dabt`. The other side's registers keep their values.
- R12: If a software write and an abort capture target the same fault register in the same cycle, the register takes the captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Coprocessor access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_insn | input | IW (32) | Instruction word carrying the primary number and opcode |
| acc_wdata | input | DW (32) | Write data |
| rd_valid | output | 1 | Read response valid, one cycle after a read |
| rd_data | output | DW (32) | Read response data |
| acc_undef | output | 1 | Undefined-access flag, one-cycle pulse |
| tlb_inval | output | 1 | TLB invalidate-all pulse |
| abt_valid | input | 1 | Abort capture strobe from the table walker |
| abt_kind | input | 2 | Access type of the aborted translation (2 = fetch) |
| abt_status | input | DW (32) | Fault status to capture |
| abt_addr | input | DW (32) | Faulting address to capture |
| pabt | output | 1 | Prefetch abort pulse |
| dabt | output | 1 | Data abort pulse |

## Verification
The instruction words in the bench carry busy bits outside the two fields. A decoder that sliced the wrong bits would therefore hit the wrong register or flag a legal access as undefined.

The bench writes each fault register to a distinct value and then aborts on one side. Steering that swapped the two sides, or that wrote both, shows up when the untouched side is read back. An abort of kind 3 guards against a decoder that tests only one bit of the kind.

The bench also drives a software write and a capture into the same register in the same cycle, where the wrong priority leaves the software value in place. It also writes through undefined opcodes of an implemented register and then reads the neighbouring registers, so that a decoder that fell through to a neighbour is exposed. The bench also checks that writes to primary 8 and to the control word invalidate the TLB while writes to the read-as-zero registers do not.

// File: rtl/mmu_ctl_pkg.sv
// Package: shared select codes, primary register numbers and constants for
// the MMU system control register file.
// Assumes a 4-bit primary register number and a 3-bit secondary opcode.
package mmu_ctl_pkg;

    // Storage or constant picked by one decoded access
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_TTB,
        SEL_DAC,
        SEL_DFSR,
        SEL_IFSR,
        SEL_DFAR,
        SEL_IFAR,
        SEL_PID,
        SEL_CTX,
        SEL_CPUID,
        SEL_CTYPE,
        SEL_ZERO
    } reg_sel_e;

    localparam int PRIM_W = 4;
    localparam int OP_W   = 3;

    // Primary register numbers the decoder acts on
    localparam logic [PRIM_W-1:0] PR_IDENT  = 4'd0;
    localparam logic [PRIM_W-1:0] PR_CTRL   = 4'd1;
    localparam logic [PRIM_W-1:0] PR_TTB    = 4'd2;
    localparam logic [PRIM_W-1:0] PR_DAC    = 4'd3;
    localparam logic [PRIM_W-1:0] PR_FSR    = 4'd5;
    localparam logic [PRIM_W-1:0] PR_FAR    = 4'd6;
    localparam logic [PRIM_W-1:0] PR_TLBOP  = 4'd8;
    localparam logic [PRIM_W-1:0] PR_LOCKZ  = 4'd10;
    localparam logic [PRIM_W-1:0] PR_PROC   = 4'd13;
    localparam logic [PRIM_W-1:0] PR_IMPLZ  = 4'd15;

    // Abort access type meaning instruction fetch
    localparam logic [1:0] KIND_FETCH = 2'd2;

    // Fault register sides
    localparam int SIDE_DATA = 0;
    localparam int SIDE_INSN = 1;
    localparam int SIDE_N    = 2;

    // Fixed cache type identification word
    localparam logic [31:0] CACHE_TYPE_WORD = 32'h01DD_20D2;

endpackage

// File: rtl/mmu_ctl_decode.sv
// Module: mmu_ctl_decode
// Turns a primary register number, a secondary opcode and a direction into a
// select code, an undefined flag and a TLB invalidate request.
// Assumes the caller gates all outputs with its own access strobe.
module mmu_ctl_decode
    import mmu_ctl_pkg::*;
(
    input  logic [PRIM_W-1:0] prim,
    input  logic [OP_W-1:0]   op,
    input  logic              is_write,
    output reg_sel_e          sel,
    output logic              undef,
    output logic              flush
);

    // Two-way selector for registers indexed by opcode 0 / 1
    function automatic logic pair_ok(input logic [OP_W-1:0] o);
        return (o == 3'd0) || (o == 3'd1);
    endfunction

    // Combinational decode of one access
    always_comb begin
        sel   = SEL_NONE;
        undef = 1'b0;
        flush = 1'b0;
        case (prim)
            PR_IDENT: begin
                if (is_write) begin
                    undef = 1'b1;
                end else begin
                    case (op)
                        3'd1:    sel = SEL_CTYPE;
                        3'd2:    sel = SEL_ZERO;
                        default: sel = SEL_CPUID;
                    endcase
                end
            end
            PR_CTRL: begin
                if (op == 3'd0) begin
                    sel   = SEL_CTRL;
                    flush = is_write;
                end else begin
                    undef = 1'b1;
                end
            end
            PR_TTB:  sel = SEL_TTB;
            PR_DAC:  sel = SEL_DAC;
            PR_FSR: begin
                if (pair_ok(op)) sel = (op == 3'd0) ? SEL_DFSR : SEL_IFSR;
                else             undef = 1'b1;
            end
            PR_FAR: begin
                if (pair_ok(op)) sel = (op == 3'd0) ? SEL_DFAR : SEL_IFAR;
                else             undef = 1'b1;
            end
            PR_TLBOP: begin
                if (is_write && pair_ok(op)) flush = 1'b1;
                else                         undef = 1'b1;
            end
            PR_LOCKZ, PR_IMPLZ: sel = SEL_ZERO;
            PR_PROC: begin
                if (pair_ok(op)) sel = (op == 3'd0) ? SEL_PID : SEL_CTX;
                else             undef = 1'b1;
            end
            default: undef = 1'b1;
        endcase
    end

endmodule

// File: rtl/mmu_ctl_abort.sv
// Module: mmu_ctl_abort
// Steers an abort capture to the instruction-side or data-side fault pair
// by access type and produces the matching abort requests.
// Assumes at most one abort capture per cycle.
module mmu_ctl_abort
    import mmu_ctl_pkg::*;
(
    input  logic              abt_valid,
    input  logic [1:0]        abt_kind,
    output logic [SIDE_N-1:0] cap_en,
    output logic              pabt_req,
    output logic              dabt_req
);

    logic is_fetch;

    // Classify the aborted access
    assign is_fetch = (abt_kind == KIND_FETCH);

    // One capture enable per fault side
    for (genvar s = 0; s < SIDE_N; s++) begin : g_side
        assign cap_en[s] = abt_valid && (is_fetch == (s == SIDE_INSN));
    end

    // Abort kind requests
    assign pabt_req = abt_valid &&  is_fetch;
    assign dabt_req = abt_valid && !is_fetch;

endmodule

// File: rtl/mmu_ctl_regs.sv
// Module: mmu_ctl_regs
// Register storage and read multiplexer. Capture of a fault pair takes
// priority over a software write to the same register.
// Assumes wr_en is only raised for defined writes.
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int            DW     = 32,
    parameter logic [DW-1:0] CPU_ID = 32'h5A01_0C3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DW-1:0]     wdata,
    input  logic [SIDE_N-1:0] cap_en,
    input  logic [DW-1:0]     cap_status,
    input  logic [DW-1:0]     cap_addr,
    output logic [DW-1:0]     rdata
);

    localparam logic [DW-1:0] CTYPE = DW'(CACHE_TYPE_WORD);

    logic [DW-1:0] ctrl_q, ttb_q, dac_q, pid_q, ctx_q;
    logic [DW-1:0] fsr_q [SIDE_N];
    logic [DW-1:0] far_q [SIDE_N];

    // Plain software-written registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ttb_q  <= '0;
            dac_q  <= '0;
            pid_q  <= '0;
            ctx_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_CTRL: ctrl_q <= wdata;
                SEL_TTB:  ttb_q  <= wdata;
                SEL_DAC:  dac_q  <= wdata;
                SEL_PID:  pid_q  <= wdata;
                SEL_CTX:  ctx_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // Fault status/address pair per side, capture wins over software
    for (genvar s = 0; s < SIDE_N; s++) begin : g_fault
        localparam reg_sel_e FSR_SEL = (s == SIDE_DATA) ? SEL_DFSR : SEL_IFSR;
        localparam reg_sel_e FAR_SEL = (s == SIDE_DATA) ? SEL_DFAR : SEL_IFAR;

        // Status register of this side
        always_ff @(posedge clk) begin
            if (!rst_n)                         fsr_q[s] <= '0;
            else if (cap_en[s])                 fsr_q[s] <= cap_status;
            else if (wr_en && sel == FSR_SEL)   fsr_q[s] <= wdata;
        end

        // Address register of this side
        always_ff @(posedge clk) begin
            if (!rst_n)                         far_q[s] <= '0;
            else if (cap_en[s])                 far_q[s] <= cap_addr;
            else if (wr_en && sel == FAR_SEL)   far_q[s] <= wdata;
        end
    end

    // Read multiplexer
    always_comb begin
        case (sel)
            SEL_CTRL:  rdata = ctrl_q;
            SEL_TTB:   rdata = ttb_q;
            SEL_DAC:   rdata = dac_q;
            SEL_DFSR:  rdata = fsr_q[SIDE_DATA];
            SEL_IFSR:  rdata = fsr_q[SIDE_INSN];
            SEL_DFAR:  rdata = far_q[SIDE_DATA];
            SEL_IFAR:  rdata = far_q[SIDE_INSN];
            SEL_PID:   rdata = pid_q;
            SEL_CTX:   rdata = ctx_q;
            SEL_CPUID: rdata = CPU_ID;
            SEL_CTYPE: rdata = CTYPE;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/mmu_ctl_regfile.sv
// Module: mmu_ctl_regfile
// Top of the MMU system control register file: decodes coprocessor
// accesses, holds the MMU registers, captures aborts and registers every
// response so that it appears one cycle after its cause.
// Assumes IW covers bit 19 and DW is at least 32.
module mmu_ctl_regfile
    import mmu_ctl_pkg::*;
#(
    parameter int            IW       = 32,
    parameter int            DW       = 32,
    parameter int            PRIM_LSB = 16,
    parameter int            OP_LSB   = 5,
    parameter logic [DW-1:0] CPU_ID   = 32'h5A01_0C3F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [IW-1:0] acc_insn,
    input  logic [DW-1:0] acc_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          acc_undef,
    output logic          tlb_inval,
    input  logic          abt_valid,
    input  logic [1:0]    abt_kind,
    input  logic [DW-1:0] abt_status,
    input  logic [DW-1:0] abt_addr,
    output logic          pabt,
    output logic          dabt
);

    localparam int PRIM_MSB = PRIM_LSB + PRIM_W - 1;
    localparam int OP_MSB   = OP_LSB + OP_W - 1;

    logic [PRIM_W-1:0] prim;
    logic [OP_W-1:0]   op;
    reg_sel_e          sel;
    logic              dec_undef, dec_flush;
    logic              wr_en, rd_en;
    logic [DW-1:0]     rdata;
    logic [SIDE_N-1:0] cap_en;
    logic              pabt_req, dabt_req;
    logic              unused_insn;

    // Field extraction from the instruction word
    assign prim        = acc_insn[PRIM_MSB:PRIM_LSB];
    assign op          = acc_insn[OP_MSB:OP_LSB];
    assign unused_insn = ^acc_insn;

    mmu_ctl_decode u_dec (
        .prim     (prim),
        .op       (op),
        .is_write (acc_write),
        .sel      (sel),
        .undef    (dec_undef),
        .flush    (dec_flush)
    );

    // Access qualification
    assign wr_en = acc_valid &&  acc_write && !dec_undef;
    assign rd_en = acc_valid && !acc_write;

    mmu_ctl_abort u_abt (
        .abt_valid (abt_valid),
        .abt_kind  (abt_kind),
        .cap_en    (cap_en),
        .pabt_req  (pabt_req),
        .dabt_req  (dabt_req)
    );

    mmu_ctl_regs #(
        .DW     (DW),
        .CPU_ID (CPU_ID)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .sel        (sel),
        .wdata      (acc_wdata),
        .cap_en     (cap_en),
        .cap_status (abt_status),
        .cap_addr   (abt_addr),
        .rdata      (rdata)
    );

    // Registered response and pulse outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            acc_undef <= 1'b0;
            tlb_inval <= 1'b0;
            pabt      <= 1'b0;
            dabt      <= 1'b0;
        end else begin
            rd_valid  <= rd_en;
            rd_data   <= (rd_en && !dec_undef) ? rdata : '0;
            acc_undef <= acc_valid && dec_undef;
            tlb_inval <= acc_valid && acc_write && dec_flush;
            pabt      <= pabt_req;
            dabt      <= dabt_req;
        end
    end

endmodule

// File: rtl/mmu_ctl_regfile_chk.sv
// Module: mmu_ctl_regfile_chk
// Port-level properties of the register file, bound to every instance.
module mmu_ctl_regfile_chk #(
    parameter int IW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic          acc_write,
    input logic [IW-1:0] acc_insn,
    input logic          rd_valid,
    input logic [DW-1:0] rd_data,
    input logic          acc_undef,
    input logic          tlb_inval,
    input logic          abt_valid,
    input logic [1:0]    abt_kind,
    input logic          pabt,
    input logic          dabt
);

    logic [3:0] p;
    logic [2:0] o;
    // Field view for the properties
    assign p = acc_insn[19:16];
    assign o = acc_insn[7:5];

    // R3
    reserved_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && (p == 4'd4 || p == 4'd11 || p == 4'd12 || p == 4'd14) |=> acc_undef);

    // R7
    tlb_op_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write && p == 4'd8 && o <= 3'd1 |=> tlb_inval && !acc_undef);

    // R11
    fetch_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abt_valid && abt_kind == 2'd2 |=> pabt && !dabt);

    // R11
    data_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abt_valid && abt_kind != 2'd2 |=> dabt && !pabt);

    // R2
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> rd_valid);

    // R2
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rd_valid && !acc_undef && !tlb_inval && rd_data == '0);

    // R9
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && (p == 4'd10 || p == 4'd15) |=> rd_data == '0 && !acc_undef);

    // R8
    ctype_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write && p == 4'd0 && o == 3'd1 |=> rd_data == DW'(32'h01DD_20D2));

endmodule

bind mmu_ctl_regfile mmu_ctl_regfile_chk #(.IW(IW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_insn  (acc_insn),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .acc_undef (acc_undef),
    .tlb_inval (tlb_inval),
    .abt_valid (abt_valid),
    .abt_kind  (abt_kind),
    .pabt      (pabt),
    .dabt      (dabt)
);

// File: tb/mmu_ctl_regfile_bench.sv
// Bench: driver tasks queue expected responses, a monitor compares them one
// cycle after each drive.
module mmu_ctl_regfile_bench;

    localparam logic [31:0] CPUID = 32'h5A01_0C3F;
    localparam logic [31:0] CTYPE = 32'h01DD_20D2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [31:0] acc_insn = '0, acc_wdata = '0;
    logic        rd_valid, acc_undef, tlb_inval, pabt, dabt;
    logic [31:0] rd_data;
    logic        abt_valid = 1'b0;
    logic [1:0]  abt_kind = '0;
    logic [31:0] abt_status = '0, abt_addr = '0;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic        rv;
        logic [31:0] rd;
        logic        und;
        logic        fl;
        logic        pa;
        logic        da;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mmu_ctl_regfile u_mmu_ctl_regfile (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_insn(acc_insn), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .acc_undef(acc_undef), .tlb_inval(tlb_inval),
        .abt_valid(abt_valid), .abt_kind(abt_kind), .abt_status(abt_status),
        .abt_addr(abt_addr), .pabt(pabt), .dabt(dabt)
    );

    // Instruction word with busy bits outside both fields (R2)
    function automatic logic [31:0] mk(input logic [3:0] pr, input logic [2:0] o);
        return {12'hABC, pr, 8'h5A, o, 5'h15};
    endfunction

    // Drive one cycle and queue its expected response
    task automatic step(input bit v, input bit w, input logic [3:0] pr, input logic [2:0] o,
                        input logic [31:0] wd, input bit av, input logic [1:0] kind,
                        input logic [31:0] st, input logic [31:0] ad,
                        input logic [31:0] exp_rd, input bit exp_und, input bit exp_fl,
                        input string tag);
        exp_t e;
        @(negedge clk);
        acc_valid = v; acc_write = w; acc_insn = mk(pr, o); acc_wdata = wd;
        abt_valid = av; abt_kind = kind; abt_status = st; abt_addr = ad;
        e.due = cyc + 1;
        e.rv  = v && !w;
        e.rd  = exp_rd;
        e.und = exp_und;
        e.fl  = exp_fl;
        e.pa  = av && kind == 2'd2;
        e.da  = av && kind != 2'd2;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wr(input logic [3:0] pr, input logic [2:0] o, input logic [31:0] d,
                      input bit und, input bit fl, input string tag);
        step(1, 1, pr, o, d, 0, 0, 0, 0, 0, und, fl, tag);
    endtask

    task automatic rd(input logic [3:0] pr, input logic [2:0] o, input logic [31:0] ex,
                      input bit und, input string tag);
        step(1, 0, pr, o, 32'hFFFF_FFFF, 0, 0, 0, 0, ex, und, 0, tag);
    endtask

    task automatic ab(input logic [1:0] kind, input logic [31:0] st, input logic [31:0] ad,
                      input string tag);
        step(0, 0, 0, 0, 0, 1, kind, st, ad, 0, 0, 0, tag);
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = 0; acc_write = 0; abt_valid = 0;
    endtask

    // Monitor: compare due items, otherwise expect a quiet cycle
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (mon_on) begin
                exp_t e;
                if (q.size() > 0 && q[0].due == cyc) begin
                    e = q.pop_front();
                end else begin
                    e.due = cyc; e.rv = 0; e.rd = 0; e.und = 0; e.fl = 0;
                    e.pa = 0; e.da = 0; e.tag = "R2 quiet cycle";
                end
                n_chk++;
                if (rd_valid !== e.rv || rd_data !== e.rd || acc_undef !== e.und ||
                    tlb_inval !== e.fl || pabt !== e.pa || dabt !== e.da) begin
                    n_bad++;
                    $display("FAIL %s: got rv=%b rd=%h und=%b fl=%b pa=%b da=%b exp rv=%b rd=%h und=%b fl=%b pa=%b da=%b",
                             e.tag, rd_valid, rd_data, acc_undef, tlb_inval, pabt, dabt,
                             e.rv, e.rd, e.und, e.fl, e.pa, e.da);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Stimulus
    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_chk++;
        if (rd_valid !== 0 || rd_data !== 0 || acc_undef !== 0 || tlb_inval !== 0 ||
            pabt !== 0 || dabt !== 0) begin
            n_bad++;
            $display("FAIL R1 outputs in reset: got %b%b%b%b%b rd=%h exp all zero",
                     rd_valid, acc_undef, tlb_inval, pabt, dabt, rd_data);
        end
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: reset values
        rd(1, 0, 0, 0, "R1 ctrl reset");
        rd(2, 0, 0, 0, "R1 ttb reset");
        rd(3, 0, 0, 0, "R1 dac reset");
        rd(5, 0, 0, 0, "R1 dfsr reset");
        rd(5, 1, 0, 0, "R1 ifsr reset");
        rd(6, 0, 0, 0, "R1 dfar reset");
        rd(6, 1, 0, 0, "R1 ifar reset");
        rd(13, 0, 0, 0, "R1 pid reset");
        rd(13, 1, 0, 0, "R1 ctx reset");

        // R8: identification reads
        rd(0, 0, CPUID, 0, "R8 cpu id op0");
        rd(0, 1, CTYPE, 0, "R8 cache type");
        rd(0, 2, 0, 0, "R8 op2 zero");
        rd(0, 7, CPUID, 0, "R8 cpu id op7");

        // R5: table base and domain access with any opcode
        wr(2, 3, 32'h1234_5678, 0, 0, "R5 ttb write");
        rd(2, 0, 32'h1234_5678, 0, "R5 ttb read");
        wr(3, 7, 32'hDEAD_BEEF, 0, 0, "R5 dac write");
        rd(3, 2, 32'hDEAD_BEEF, 0, "R5 dac read");

        // R4: control write flushes
        wr(1, 0, 32'h0000_0079, 0, 1, "R4 ctrl write");
        rd(1, 0, 32'h0000_0079, 0, "R4 ctrl read");

        // R6: fault registers by opcode
        wr(5, 0, 32'hA0A0_0001, 0, 0, "R6 dfsr write");
        wr(5, 1, 32'hB0B0_0002, 0, 0, "R6 ifsr write");
        wr(6, 0, 32'hC0C0_0003, 0, 0, "R6 dfar write");
        wr(6, 1, 32'hD0D0_0004, 0, 0, "R6 ifar write");
        rd(5, 0, 32'hA0A0_0001, 0, "R6 dfsr read");
        rd(5, 1, 32'hB0B0_0002, 0, "R6 ifsr read");
        rd(6, 0, 32'hC0C0_0003, 0, "R6 dfar read");
        rd(6, 1, 32'hD0D0_0004, 0, "R6 ifar read");

        // R10: process and context identifiers
        wr(13, 0, 32'h0300_0000, 0, 0, "R10 pid write");
        wr(13, 1, 32'h0000_00AB, 0, 0, "R10 ctx write");
        rd(13, 0, 32'h0300_0000, 0, "R10 pid read");
        rd(13, 1, 32'h0000_00AB, 0, "R10 ctx read");

        // R7: TLB operation register
        wr(8, 0, 32'h5555_5555, 0, 1, "R7 tlb op0");
        wr(8, 1, 32'h6666_6666, 0, 1, "R7 tlb op1");
        rd(1, 0, 32'h0000_0079, 0, "R7 ctrl unchanged");
        rd(2, 0, 32'h1234_5678, 0, "R7 ttb unchanged");

        // R3: reserved and unimplemented encodings
        rd(4, 0, 0, 1, "R3 read p4");
        rd(11, 0, 0, 1, "R3 read p11");
        rd(12, 3, 0, 1, "R3 read p12");
        rd(14, 0, 0, 1, "R3 read p14");
        rd(7, 0, 0, 1, "R3 read p7");
        rd(9, 0, 0, 1, "R3 read p9");
        wr(4, 0, 32'h1111_1111, 1, 0, "R3 write p4");
        wr(0, 0, 32'h2222_2222, 1, 0, "R3 write p0");
        wr(1, 2, 32'h3333_3333, 1, 0, "R3 write p1 op2");
        rd(1, 1, 0, 1, "R3 read p1 op1");
        rd(8, 0, 0, 1, "R3 read p8");
        wr(8, 2, 32'h4444_4444, 1, 0, "R3 write p8 op2");
        rd(5, 2, 0, 1, "R3 read p5 op2");
        wr(5, 3, 32'h7777_7777, 1, 0, "R3 write p5 op3");
        wr(6, 4, 32'h8888_8888, 1, 0, "R3 write p6 op4");
        wr(13, 2, 32'h9999_9999, 1, 0, "R3 write p13 op2");
        rd(1, 0, 32'h0000_0079, 0, "R3 ctrl unchanged");
        rd(5, 0, 32'hA0A0_0001, 0, "R3 dfsr unchanged");
        rd(5, 1, 32'hB0B0_0002, 0, "R3 ifsr unchanged");
        rd(6, 1, 32'hD0D0_0004, 0, "R3 ifar unchanged");
        rd(13, 0, 32'h0300_0000, 0, "R3 pid unchanged");
        rd(13, 1, 32'h0000_00AB, 0, "R3 ctx unchanged");

        // R9: read-as-zero registers
        wr(10, 0, 32'hFFFF_0000, 0, 0, "R9 write p10");
        wr(15, 5, 32'h0000_FFFF, 0, 0, "R9 write p15");
        rd(10, 0, 0, 0, "R9 read p10");
        rd(15, 3, 0, 0, "R9 read p15");

        // R11: abort capture steering
        ab(2, 32'h0000_0005, 32'h0000_1000, "R11 fetch abort");
        rd(5, 1, 32'h0000_0005, 0, "R11 ifsr captured");
        rd(6, 1, 32'h0000_1000, 0, "R11 ifar captured");
        rd(5, 0, 32'hA0A0_0001, 0, "R11 dfsr kept");
        rd(6, 0, 32'hC0C0_0003, 0, "R11 dfar kept");
        ab(1, 32'h0000_00F7, 32'h8000_2004, "R11 data abort kind1");
        rd(5, 0, 32'h0000_00F7, 0, "R11 dfsr captured");
        rd(6, 0, 32'h8000_2004, 0, "R11 dfar captured");
        rd(5, 1, 32'h0000_0005, 0, "R11 ifsr kept");
        ab(3, 32'h0000_0013, 32'h0000_3300, "R11 data abort kind3");
        rd(6, 0, 32'h0000_3300, 0, "R11 dfar kind3");
        rd(6, 1, 32'h0000_1000, 0, "R11 ifar kept kind3");
        ab(0, 32'h0000_0021, 32'h0000_4400, "R11 data abort kind0");
        rd(5, 0, 32'h0000_0021, 0, "R11 dfsr kind0");

        // R12: capture wins over a same-cycle software write
        step(1, 1, 5, 0, 32'hEEEE_EEEE, 1, 0, 32'h0000_0077, 32'h0000_5500, 0, 0, 0,
             "R12 write dfsr with data abort");
        rd(5, 0, 32'h0000_0077, 0, "R12 dfsr holds capture");
        step(1, 1, 6, 1, 32'h1357_9BDF, 1, 0, 32'h0000_0088, 32'h0000_6600, 0, 0, 0,
             "R12 write ifar with data abort");
        rd(6, 1, 32'h1357_9BDF, 0, "R12 ifar takes software");
        rd(6, 0, 32'h0000_6600, 0, "R12 dfar takes capture");

        idle();
        repeat (4) @(posedge clk);
        #3;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 pending responses: got %0d exp 0", q.size());
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule